// File: doc/BRIEF.md
# Dual-Clock Skew Error Detector

The block watches two slow clocks that should move in lockstep: a count clock and a companion check clock. Each rising edge of the count clock should be paired with a falling edge of the check clock, and the reverse also holds. Both clocks are sampled as ordinary data inputs on a fast sampling clock. Whichever edge arrives first opens a skew window for its own direction. The opposite edge must arrive before that window runs out. If it does not, one error is counted.

Each direction has its own window length, set in sampling-clock cycles. An error counter saturates at three. Once it reaches three, a sticky alarm output goes high and stays high until the master reset. An enable input lets the monitor be switched off, for example when the check clock is tied static and pairing is not wanted.

Top module: `skew_err_det`

## Requirements
- R1: Count-first window. A rising edge on `cnt_clk_i` opens window 1. A falling edge on `chk_clk_i` that arrives 0 to L1 sampling cycles later closes it with no error, where L1 = `win1_i` (a value of 0 acts as 1). If no falling edge arrives by cycle L1, one error is counted and window 1 closes.
- R2: Check-first window. A falling edge on `chk_clk_i` opens window 2. A rising edge on `cnt_clk_i` that arrives 0 to L2 cycles later closes it with no error, where L2 = `win2_i` (0 acts as 1). Otherwise one error is counted.
- R3: An edge that closes the open window of the other direction does not open a window of its own. An edge that arrives after the other window has expired opens its own window. At most one window is open at a time. The two window lengths are independent.
- R4: `err_cnt_o` reports the number of errors counted, from 0 to 3. `err_o` is 1 exactly when that count is 3.
- R5: A high `mrst_i` on a sampling edge clears the count, `err_o` and both windows.
- R6: The count saturates at 3, so `err_o` stays high through any further errors until a clear.
- R7: While `en_i` is 0, both windows are closed and no errors are counted. Unpaired count-clock edges therefore leave `err_cnt_o` unchanged.
- R8: A second count-clock rising edge that arrives while window 1 is still open counts one error for the unmatched first edge and restarts window 1.
- R9: While `rst_ni` is low, `err_cnt_o` is 0 and `err_o` is 0. Window settings are changed only while no window is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mrst_i | input | 1 | Synchronous master reset, active high |
| en_i | input | 1 | Detection enable |
| cnt_clk_i | input | 1 | Monitored count clock |
| chk_clk_i | input | 1 | Monitored check clock |
| win1_i | input | WIN_W | Window length, count-first direction |
| win2_i | input | WIN_W | Window length, check-first direction |
| err_cnt_o | output | 2 | Saturating error count |
| err_o | output | 1 | Sticky alarm, high at three errors |

## Verification
A window timer that closes one cycle early or late shows up directly as a wrong `err_cnt_o` after the boundary pairings at distances L and L+1. That result settles within the window length plus the synchronizer latency of three cycles. Wrong pairing logic, for example an edge that both closes a window and opens a new one, shows as a count that is too high by one or two after an otherwise matched pair. The directed cases are chosen so that each wrong behaviour gives a different count, whether the late edge starts its own window or a restart is missed. A broken saturation or clear appears at `err_o` on the first sampling cycle after the fourth error or after the master reset.

// File: rtl/skew_det_pkg.sv
package skew_det_pkg;
  localparam int unsigned ERR_LIMIT = 3;
  localparam int unsigned ERR_CNT_W = 2;
  typedef logic [ERR_CNT_W-1:0] err_cnt_t;
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/skew_edge_sync.sv
module skew_edge_sync
  import skew_det_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  d_i,
  output edge_t edge_o
);
  // q[STAGES-1] is the synchronized value, q[STAGES] the previous sample
  logic [STAGES:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q[0] <= 1'b0;
    else         q[0] <= d_i;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q[i] <= 1'b0;
      else         q[i] <= q[i-1];
    end
  end

  assign edge_o.rise = q[STAGES-1] & ~q[STAGES];
  assign edge_o.fall = ~q[STAGES-1] & q[STAGES];
endmodule

// File: rtl/skew_window.sv
module skew_window #(
  parameter int unsigned WIN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             open_i,
  input  logic             close_i,
  input  logic [WIN_W-1:0] win_i,
  output logic             open_o,
  output logic             miss_o
);
  logic             open_q;
  logic [WIN_W-1:0] tmr_q;
  logic [WIN_W-1:0] lim;
  logic             run;

  assign lim = (win_i == '0) ? WIN_W'(1) : win_i;
  assign run = en_i && !clr_i;

  always_comb begin
    miss_o = 1'b0;
    if (run) begin
      if (open_i)                                   miss_o = open_q;
      else if (open_q && !close_i && tmr_q >= lim)  miss_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      tmr_q  <= '0;
    end else if (!run) begin
      open_q <= 1'b0;
      tmr_q  <= '0;
    end else if (open_i) begin
      open_q <= 1'b1;
      tmr_q  <= WIN_W'(1);
    end else if (open_q) begin
      if (close_i || tmr_q >= lim) begin
        open_q <= 1'b0;
        tmr_q  <= '0;
      end else begin
        tmr_q <= tmr_q + WIN_W'(1);
      end
    end
  end

  assign open_o = open_q;

  // window never runs past its limit (settings held while open)
  assert_win_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_q |-> (tmr_q <= lim && tmr_q != '0));
  // disabled monitor keeps the window shut
  assert_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !open_o);
  // a miss always retires the running window or restarts it
  assert_miss_close_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_o && !open_i) |=> !open_o);
endmodule

// File: rtl/skew_err_accum.sv
module skew_err_accum
  import skew_det_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clr_i,
  input  logic     miss1_i,
  input  logic     miss2_i,
  output err_cnt_t cnt_o
);
  localparam int unsigned SUM_W = ERR_CNT_W + 1;
  err_cnt_t         cnt_q;
  logic [SUM_W-1:0] sum;

  assign sum = SUM_W'(cnt_q) + SUM_W'(miss1_i) + SUM_W'(miss2_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (clr_i)                       cnt_q <= '0;
    else if (sum >= SUM_W'(ERR_LIMIT))    cnt_q <= err_cnt_t'(ERR_LIMIT);
    else                                  cnt_q <= sum[ERR_CNT_W-1:0];
  end

  assign cnt_o = cnt_q;

  assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == err_cnt_t'(ERR_LIMIT) && !clr_i) |=> cnt_q == err_cnt_t'(ERR_LIMIT));
  assert_monotonic_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> cnt_q >= $past(cnt_q));
  assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/skew_err_det.sv
module skew_err_det
  import skew_det_pkg::*;
#(
  parameter int unsigned WIN_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mrst_i,
  input  logic             en_i,
  input  logic             cnt_clk_i,
  input  logic             chk_clk_i,
  input  logic [WIN_W-1:0] win1_i,
  input  logic [WIN_W-1:0] win2_i,
  output logic [1:0]       err_cnt_o,
  output logic             err_o
);
  localparam int unsigned NCLK = 2;

  logic [NCLK-1:0] clk_in;
  edge_t           edg [NCLK];
  logic            cnt_rise, chk_fall;
  logic            w1_open, w2_open, w1_req, w2_req, miss1, miss2;
  err_cnt_t        cnt;

  assign clk_in = {chk_clk_i, cnt_clk_i};

  for (genvar i = 0; i < NCLK; i++) begin : g_sync
    skew_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (clk_in[i]),
      .edge_o(edg[i])
    );
  end

  assign cnt_rise = edg[0].rise;
  assign chk_fall = edg[1].fall;

  // an edge answering the opposite open window never opens its own
  assign w1_req = cnt_rise && !chk_fall && !w2_open;
  assign w2_req = chk_fall && !cnt_rise && !w1_open;

  skew_window #(.WIN_W(WIN_W)) u_win1 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (mrst_i),
    .en_i   (en_i),
    .open_i (w1_req),
    .close_i(chk_fall),
    .win_i  (win1_i),
    .open_o (w1_open),
    .miss_o (miss1)
  );

  skew_window #(.WIN_W(WIN_W)) u_win2 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (mrst_i),
    .en_i   (en_i),
    .open_i (w2_req),
    .close_i(cnt_rise),
    .win_i  (win2_i),
    .open_o (w2_open),
    .miss_o (miss2)
  );

  skew_err_accum u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (mrst_i),
    .miss1_i(miss1),
    .miss2_i(miss2),
    .cnt_o  (cnt)
  );

  assign err_cnt_o = cnt;
  assign err_o     = (cnt == err_cnt_t'(ERR_LIMIT));

  assert_one_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(w1_open && w2_open));
  assert_alarm_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !mrst_i) |=> err_o);
  assert_alarm_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrst_i |=> !err_o && err_cnt_o == 2'd0);
endmodule

// File: tb/skew_err_det_test.sv
module skew_err_det_test;
  localparam int CLK_PERIOD = 10;
  localparam int WIN_W      = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             mrst_i = 1'b0;
  logic             en_i = 1'b1;
  logic             cnt_clk_i = 1'b0;
  logic             chk_clk_i = 1'b1;
  logic [WIN_W-1:0] win1_i = 8'd4;
  logic [WIN_W-1:0] win2_i = 8'd6;
  logic [1:0]       err_cnt_o;
  logic             err_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  skew_err_det #(.WIN_W(WIN_W), .SYNC_STAGES(2)) uut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mrst_i   (mrst_i),
    .en_i     (en_i),
    .cnt_clk_i(cnt_clk_i),
    .chk_clk_i(chk_clk_i),
    .win1_i   (win1_i),
    .win2_i   (win2_i),
    .err_cnt_o(err_cnt_o),
    .err_o    (err_o)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic expect_state(input string req, input int exp_cnt, input bit exp_err);
    checks++;
    if (int'(err_cnt_o) !== exp_cnt || err_o !== exp_err) begin
      errors++;
      $display("FAIL %s: cnt=%0d err=%0b expected cnt=%0d err=%0b",
               req, err_cnt_o, err_o, exp_cnt, exp_err);
    end
  endtask

  task automatic clear_errs();
    mrst_i = 1'b1; cyc(1); mrst_i = 1'b0; cyc(2);
  endtask

  // count clock rises, check clock falls d cycles later
  task automatic count_first(input int d);
    cnt_clk_i = 1'b1;
    if (d == 0) chk_clk_i = 1'b0;
    else begin cyc(d); chk_clk_i = 1'b0; end
    cyc(2); cnt_clk_i = 1'b0;
    cyc(30); chk_clk_i = 1'b1; cyc(4);
  endtask

  // check clock falls, count clock rises d cycles later
  task automatic check_first(input int d);
    chk_clk_i = 1'b0;
    cyc(d); cnt_clk_i = 1'b1;
    cyc(2); chk_clk_i = 1'b1;
    cyc(30); cnt_clk_i = 1'b0; cyc(4);
  endtask

  task automatic lone_rise();
    cnt_clk_i = 1'b1; cyc(3); cnt_clk_i = 1'b0; cyc(20);
  endtask

  task automatic t_reset();
    cyc(2);
    expect_state("R9 reset", 0, 1'b0);
    rst_ni = 1'b1; cyc(6);
    expect_state("R9 after reset", 0, 1'b0);
  endtask

  task automatic t_count_first();
    win1_i = 8'd4; win2_i = 8'd6;
    clear_errs(); count_first(0); expect_state("R1 same cycle", 0, 1'b0);
    clear_errs(); count_first(4); expect_state("R1 edge of window", 0, 1'b0);
    // late fall: window 1 misses, late fall opens window 2 which misses too
    clear_errs(); count_first(5); expect_state("R1 R3 late fall", 2, 1'b0);
  endtask

  task automatic t_check_first();
    win1_i = 8'd4; win2_i = 8'd6;
    clear_errs(); check_first(6); expect_state("R2 R3 wide window 2", 0, 1'b0);
    clear_errs(); check_first(7); expect_state("R2 late rise", 2, 1'b0);
  endtask

  task automatic t_zero_window();
    win1_i = 8'd0; win2_i = 8'd6;
    clear_errs(); count_first(1); expect_state("R1 zero acts as one", 0, 1'b0);
    clear_errs(); count_first(2); expect_state("R1 zero window miss", 2, 1'b0);
    win1_i = 8'd4;
  endtask

  task automatic t_saturate();
    clear_errs();
    lone_rise(); expect_state("R4 one error", 1, 1'b0);
    lone_rise(); lone_rise(); expect_state("R4 three errors", 3, 1'b1);
    lone_rise(); lone_rise(); expect_state("R6 saturate", 3, 1'b1);
    clear_errs(); expect_state("R5 master reset", 0, 1'b0);
  endtask

  task automatic t_disable();
    clear_errs();
    en_i = 1'b0;
    lone_rise(); lone_rise(); lone_rise();
    expect_state("R7 disabled", 0, 1'b0);
    en_i = 1'b1; cyc(3);
  endtask

  task automatic t_rearm();
    win1_i = 8'd10;
    clear_errs();
    cnt_clk_i = 1'b1; cyc(2); cnt_clk_i = 1'b0; cyc(2);
    cnt_clk_i = 1'b1; cyc(2); chk_clk_i = 1'b0; cyc(2); cnt_clk_i = 1'b0;
    cyc(30); chk_clk_i = 1'b1; cyc(4);
    expect_state("R8 restart", 1, 1'b0);
    win1_i = 8'd4;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_count_first();
    t_check_first();
    t_zero_window();
    t_saturate();
    t_disable();
    t_rearm();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule